// File: doc/BRIEF.md
# Reversible-Gate Static Memory Array

This block is a 16-word by 8-bit static memory. Every storage bit and every access path in it is assembled from two reversible gate primitives. The first is a controlled swap gate with outputs P=A, Q=A?C:B and R=A?B:C. The second is a controlled NOT gate with outputs P=A and Q=A^B. Each bit cell has two parts: a swap gate that acts as the access stage, and a latch built from one swap gate and one controlled NOT gate around a single state flop. The access stage passes its select input along to the next cell of the row, so a word line enters a row once and ripples through it rather than fanning out from the decoder.

A 4-bit address is decoded in two levels of 2-to-4 decoders with enables. The upper decoder takes address bits [3:2] and is enabled by write enable. Each of its four outputs enables one lower decoder, which takes address bits [1:0]. Word lines therefore rise only during writes. Reads use a registered column select: the read data is valid one clock after the address is presented. Synchronous reset also travels through the gates. An active-high clear line is chained through the latch swap gates and forces every state flop to 0.

Each cell leaves exactly one gate output unconsumed: the R output of its access gate. The block reports the total of these unused outputs on a constant debug port.

Top module: `rev_sram`

## Requirements
- R1: In a clock edge with rst_n low, every word is cleared to 0x00 and rdata becomes 0x00.
- R2: In a clock edge with we high, the word at addr takes the value of wdata.
- R3: rdata is registered. After the edge at which addr was presented, rdata holds the word stored at addr as it was before that edge.
- R4: A write changes only the addressed word. The other 15 words keep their values.
- R5: While we is low, no word changes whatever addr and wdata are, because all word lines stay low.
- R6: A read and a write to the same address in one cycle return the old word on rdata. The new word appears on the next read.
- R7: Word index equals addr. addr[3:2] selects the group of four and addr[1:0] selects the row within it. At most one word line is high at any time.
- R8: garbage_count equals the number of cells times one unused output per cell, which is 128 for 16 by 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Word address for both read and write |
| we | input | 1 | Write enable |
| wdata | input | 8 | Data written to the addressed word |
| rdata | output | 8 | Registered read data of the addressed word |
| garbage_count | output | 8 | Constant count of unconsumed gate outputs |

## Verification
A broken decoder or word-line chain shows up as a write that lands in the wrong word, or in no word at all. The next read of either word then shows a mismatch on rdata, two cycles after the faulty write at the earliest. A cell whose access gate or latch feedback is wrong either loses its value while idle or ignores new data. So the bench mixes long idle stretches and disabled-write cycles with random writes, and rereads every address. A fault in the clear path leaves nonzero words after reset, which the sweep of all 16 addresses that follows reset exposes.

// File: rtl/rev_sram_pkg.sv
// Package: shared sizes for the reversible-gate memory.
// Assumes a fixed 16-word array so that two levels of 2-to-4 decoding suffice.
package rev_sram_pkg;
    localparam int WORDS          = 16;
    localparam int ADDR_W         = $clog2(WORDS);
    localparam int GROUPS         = WORDS / 4;
    localparam int GARB_PER_CELL  = 1;
endpackage

// File: rtl/rv_fredkin.sv
// Controlled swap gate: P passes the control, Q/R swap B and C when A is high.
// Assumes nothing; purely combinational.
module rv_fredkin (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    // Swap data inputs under control of a
    always_comb begin
        p = a;
        q = a ? c : b;
        r = a ? b : c;
    end
endmodule

// File: rtl/rv_feynman.sv
// Controlled NOT gate: P passes the control, Q is B inverted when A is high.
// Assumes nothing; purely combinational.
module rv_feynman (
    input  logic a,
    input  logic b,
    output logic p,
    output logic q
);
    // XOR target with control
    always_comb begin
        p = a;
        q = a ^ b;
    end
endmodule

// File: rtl/rv_dec2to4.sv
// 2-to-4 decoder with enable: one-hot output when en is high, zero otherwise.
// Assumes sel is a plain binary index.
module rv_dec2to4 (
    input  logic       en,
    input  logic [1:0] sel,
    output logic [3:0] y
);
    // Decode sel into a one-hot vector gated by en
    always_comb begin
        y = 4'b0000;
        if (en) y[sel] = 1'b1;
    end
endmodule

// File: rtl/rv_wordline_dec.sv
// Two-level word-line decoder: upper bits pick a group, lower bits a row in it.
// Assumes WORDS is 16, i.e. a 4-bit address split into two 2-bit fields.
module rv_wordline_dec
    import rev_sram_pkg::*;
(
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORDS-1:0]  wl
);
    logic [GROUPS-1:0] grp_en;

    rv_dec2to4 u_hi (
        .en  (en),
        .sel (addr[3:2]),
        .y   (grp_en)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_lo
        rv_dec2to4 u_lo (
            .en  (grp_en[g]),
            .sel (addr[1:0]),
            .y   (wl[4*g+3 -: 4])
        );
    end

    // Check word-line legality whenever inputs are known
    always_comb begin
        if (!$isunknown({en, addr})) begin
            p_wl_onehot_r7: assert ($onehot0(wl));
            p_wl_idle_r5:   assert (en || (wl == '0));
        end
    end
endmodule

// File: rtl/rv_bitcell.sv
// One storage bit: a swap-gate access stage feeding a latch made of one swap
// gate (synchronous clear) and one controlled NOT gate (read tap and feedback).
// Assumes wl_in and clr_in are never high together in normal use; clear wins.
// The access gate R output is the single unconsumed output of the cell.
module rv_bitcell (
    input  logic clk,
    input  logic wl_in,
    input  logic clr_in,
    input  logic bl,
    output logic wl_out,
    output logic clr_out,
    output logic tap
);
    logic held, nxt, garbage;
    logic d_in, clr_r;
    logic state_q;

    // Access stage: word line low keeps held bit, high takes bit line
    rv_fredkin u_access (
        .a (wl_in),
        .b (held),
        .c (bl),
        .p (wl_out),
        .q (nxt),
        .r (garbage)
    );

    // Latch clear gate: forces 0 into the flop while clr_in is high
    rv_fredkin u_latch_clr (
        .a (clr_in),
        .b (nxt),
        .c (1'b0),
        .p (clr_out),
        .q (d_in),
        .r (clr_r)
    );

    // Latch state element
    always_ff @(posedge clk) begin
        state_q <= d_in;
    end

    // Latch feedback gate: returns state to the access stage and the read tap
    rv_feynman u_latch_fb (
        .a (state_q),
        .b (clr_r),
        .p (held),
        .q (tap)
    );

    p_cell_hold_r5: assert property (@(posedge clk) disable iff (clr_in)
        (!wl_in && !clr_in) |=> (tap == $past(tap)));

    p_cell_write_r2: assert property (@(posedge clk) disable iff (clr_in)
        (wl_in && !clr_in) |=> (tap == $past(bl)));

    p_garbage_old_r8: assert property (@(posedge clk) disable iff (clr_in)
        (wl_in && !clr_in) |-> (garbage == tap));
endmodule

// File: rtl/rv_row.sv
// One word: DATA_W cells with the word line and clear line rippling through.
// Assumes wl_in is already gated by write enable upstream.
module rv_row #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wl_in,
    input  logic              clr_in,
    input  logic [DATA_W-1:0] bl,
    output logic [DATA_W-1:0] taps
);
    logic [DATA_W:0] wl_chain;
    logic [DATA_W:0] clr_chain;

    assign wl_chain[0]  = wl_in;
    assign clr_chain[0] = clr_in;

    for (genvar j = 0; j < DATA_W; j++) begin : g_cell
        rv_bitcell u_cell (
            .clk     (clk),
            .wl_in   (wl_chain[j]),
            .clr_in  (clr_chain[j]),
            .bl      (bl[j]),
            .wl_out  (wl_chain[j+1]),
            .clr_out (clr_chain[j+1]),
            .tap     (taps[j])
        );
    end

    // The chains must deliver the row's select and clear to the far end
    always_comb begin
        if (!$isunknown({wl_in, clr_in})) begin
            p_chain_end_r7: assert (wl_chain[DATA_W] == wl_in
                                    && clr_chain[DATA_W] == clr_in);
        end
    end
endmodule

// File: rtl/rev_sram.sv
// Top: 16 x DATA_W reversible-gate memory with decoded word lines, a clear
// chain from the synchronous active-low reset, and a registered read port.
// Assumes reset is held for at least one clock edge before use.
module rev_sram
    import rev_sram_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int GC_W  = $clog2(WORDS * DATA_W * GARB_PER_CELL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [GC_W-1:0]   garbage_count
);
    localparam int GARB_TOTAL = WORDS * DATA_W * GARB_PER_CELL;

    logic                 clr;
    logic [WORDS-1:0]     wl;
    logic [DATA_W-1:0]    row_taps [WORDS];

    assign clr           = ~rst_n;
    assign garbage_count = GC_W'(GARB_TOTAL);

    rv_wordline_dec u_dec (
        .en   (we & rst_n),
        .addr (addr),
        .wl   (wl)
    );

    for (genvar i = 0; i < WORDS; i++) begin : g_row
        rv_row #(.DATA_W(DATA_W)) u_row (
            .clk    (clk),
            .wl_in  (wl[i]),
            .clr_in (clr),
            .bl     (wdata),
            .taps   (row_taps[i])
        );
    end

    // Registered read of the addressed word, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= row_taps[addr];
    end

    p_rd_during_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && $stable(addr) && $past(rst_n)) |=> (rdata == $past(row_taps[addr])));

    p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |=> (row_taps[$past(addr)] == $past(row_taps[addr])));
endmodule

// File: tb/rev_sram_tb.sv
// Bench: directed corners plus seeded random traffic against a bench model.
module rev_sram_tb;
    localparam int DW = 8;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    addr = '0;
    logic          we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [7:0]    garbage_count;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [DW-1:0] model [NW];

    rev_sram #(.DATA_W(DW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (addr),
        .we            (we),
        .wdata         (wdata),
        .rdata         (rdata),
        .garbage_count (garbage_count)
    );

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] exp_read(input logic [3:0] a);
        return model[a];
    endfunction

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: present inputs at a falling edge, check rdata at the next one
    task automatic op(input logic [3:0] a, input logic w, input logic [DW-1:0] d,
                      input string req);
        logic [DW-1:0] e;
        addr = a; we = w; wdata = d;
        e = exp_read(a);
        @(negedge clk);
        check(rdata, e, req);
        if (w) model[a] = d;
        we = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) model[i] = '0;
        // stale write request during reset must not survive R1
        we = 1'b1; wdata = 8'hFF; addr = 4'd5;
        repeat (3) @(negedge clk);
        we = 1'b0;
        check(rdata, 8'h00, "R1 reset rdata");
        rst_n = 1'b1;
        n_chk++;
        if (garbage_count !== 8'd128) begin
            n_fail++;
            $display("FAIL R8: got %0d expected %0d", garbage_count, 128);
        end
        for (int i = 0; i < NW; i++) op(4'(i), 1'b0, 8'h00, "R1 cleared word");
        // R2/R7: distinct pattern per address, including 0 and 15
        for (int i = 0; i < NW; i++) op(4'(i), 1'b1, 8'(8'h11 * i + 8'h3C), "R2 write");
        for (int i = NW - 1; i >= 0; i--) op(4'(i), 1'b0, 8'h00, "R3 R7 readback");
        // R6: same-address read during write returns old, then new
        op(4'd9, 1'b1, 8'hA5, "R6 old on write");
        op(4'd9, 1'b0, 8'h00, "R6 new after write");
        op(4'd0, 1'b1, 8'hFF, "R6 old at addr 0");
        op(4'd15, 1'b1, 8'h00, "R6 old at addr 15");
        // R4: neighbours of written words untouched
        op(4'd8, 1'b0, 8'h00, "R4 neighbour 8");
        op(4'd10, 1'b0, 8'h00, "R4 neighbour 10");
        op(4'd1, 1'b0, 8'h00, "R4 neighbour 1");
        // R5: disabled writes with changing data do nothing
        for (int i = 0; i < NW; i++) op(4'(i), 1'b0, 8'(~i), "R5 no write");
        for (int i = 0; i < NW; i++) op(4'(i), 1'b0, 8'h00, "R5 after idle");
        // random mix
        for (int k = 0; k < 2000; k++) begin
            logic [3:0] a = 4'($urandom_range(0, NW - 1));
            logic w = ($urandom_range(0, 2) == 0);
            op(a, w, 8'($urandom), w ? "R2 R4 random write" : "R3 R5 random read");
        end
        // second reset clears written data
        rst_n = 1'b0;
        @(negedge clk);
        check(rdata, 8'h00, "R1 rdata on second reset");
        rst_n = 1'b1;
        for (int i = 0; i < NW; i++) model[i] = '0;
        for (int i = 0; i < NW; i++) op(4'(i), 1'b0, 8'h00, "R1 cleared again");
        finish_run();
    end
endmodule